// File: doc/BRIEF.md
# Accelerator Launch and Status Register Slave

This block is the software-facing register slave of a fixed-function accelerator. It sits on an AXI4-Lite bus and holds two words. The control word at offset 0x00 carries a start request, a completion flag, two live status bits from the core and an auto-relaunch enable. The 32-bit buffer base register at offset 0x10 tells the core where its memory buffer starts, and its value is driven to the core without change.

Software uses it in three steps. It writes the buffer's physical address to 0x10, then writes 1 to the start bit, then polls 0x00 until the completion flag reads 1. The start request remains raised towards the core until the core accepts it with its ready signal. The completion flag is cleared by the read that returns it to software. With auto-relaunch set, every completion raises the start request again, so software does not need to write start again.

Three small state machines make up the block:
- The write channel has the states W_IDLE, W_HAVE_A (address held, waiting for data), W_HAVE_D (data held, waiting for the address) and W_RESP (response pending). From W_IDLE it goes to W_RESP when both channels arrive together, to W_HAVE_A when only the address arrives, and to W_HAVE_D when only the data arrives. From W_HAVE_A or W_HAVE_D it goes to W_RESP when the missing channel arrives. From W_RESP it returns to W_IDLE when `s_bready` is high.
- The read channel has the states R_IDLE and R_RESP. It goes from R_IDLE to R_RESP when a read address is accepted, and back to R_IDLE on the data handshake.
- The launch logic holds the start, completion and auto-relaunch flags.

Top module: `acc_ctl_regs`

## Requirements
- R1: A read of offset 0x00 returns the start request in bit 0, the completion flag in bit 1, `core_idle` in bit 2, `core_ready` in bit 3 and the auto-relaunch enable in bit 7. Every other bit reads 0.
- R2: A write to 0x00 with byte strobe 0 set and data bit 0 equal to 1 raises `core_start`. `core_start` stays high until a cycle in which `core_ready` is high, and clears after that cycle. A write of 0 to bit 0 does not clear it.
- R3: A `core_done` pulse sets the completion flag on the next cycle. The flag clears only on the completed read data handshake of offset 0x00 that returned it as 1. A completion arriving after that read's address was accepted stays set for the next read.
- R4: Bits 2 and 3 of the control word follow `core_idle` and `core_ready` at the moment the read address is accepted.
- R5: A write to 0x00 with byte strobe 0 set loads data bit 7 into the auto-relaunch enable. While that enable is 1, each `core_done` pulse raises `core_start` again without any software write.
- R6: Offset 0x10 is a 32-bit read/write register. Each byte is written only when its write strobe is set. The register's value drives `base_addr`.
- R7: After a synchronous active-low reset, the base register is 0 and the start, completion and auto-relaunch flags are 0.
- R8: A read of any offset other than 0x00 and 0x10 returns 0. A write to any such offset changes no register. Both complete with an OKAY (2'b00) response.
- R9: The write address and write data may arrive together or in either order. Each write is answered by exactly one `s_bvalid` with `s_bresp` equal to 2'b00, and each read returns `s_rresp` equal to 2'b00.
- R10: Once raised, `s_bvalid` and `s_rvalid` stay high until their ready signal is seen, and `s_rdata` holds steady for that whole time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_awaddr | input | 8 | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address accepted |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data accepted |
| s_bresp | output | 2 | Write response code |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response taken |
| s_araddr | input | 8 | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address accepted |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response code |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data taken |
| core_start | output | 1 | Start request to the core |
| core_ready | input | 1 | Core can accept a start |
| core_idle | input | 1 | Core is not running |
| core_done | input | 1 | One-cycle completion pulse from the core |
| base_addr | output | 32 | Buffer base address for the core |

## Verification
A start flag that is stuck or cleared early appears on `core_start` within one cycle. The next control read or the count of core launches shows it as well. A completion flag with the wrong value appears on the first control read after the core finishes, and the read after that shows whether the clear on read took effect. A wrong byte merge or a stray write to the base register appears on `base_addr` one cycle after the write completes, and on the next read of 0x10. A write state machine that has lost track of its state shows up as a missing or duplicated `s_bvalid` on the very next access.

// File: rtl/acc_ctl_pkg.sv
package acc_ctl_pkg;
    typedef enum logic [1:0] {W_IDLE, W_HAVE_A, W_HAVE_D, W_RESP} wr_state_e;
    typedef enum logic       {R_IDLE, R_RESP} rd_state_e;

    localparam int CTRL_START = 0;
    localparam int CTRL_DONE  = 1;
    localparam int CTRL_IDLE  = 2;
    localparam int CTRL_READY = 3;
    localparam int CTRL_AUTO  = 7;

    localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/acc_ctl_wr.sv
module acc_ctl_wr
    import acc_ctl_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int STRB_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              awvalid,
    output logic              awready,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STRB_W-1:0] wstrb,
    input  logic              wvalid,
    output logic              wready,
    output logic [1:0]        bresp,
    output logic              bvalid,
    input  logic              bready,
    output logic              commit,
    output logic [ADDR_W-1:0] c_addr,
    output logic [DATA_W-1:0] c_data,
    output logic [STRB_W-1:0] c_strb
);
    wr_state_e         state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [STRB_W-1:0] strb_q;
    logic              aw_fire, w_fire;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= W_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            W_IDLE: begin
                if (aw_fire && w_fire) state_d = W_RESP;
                else if (aw_fire)      state_d = W_HAVE_A;
                else if (w_fire)       state_d = W_HAVE_D;
            end
            W_HAVE_A: if (w_fire)  state_d = W_RESP;
            W_HAVE_D: if (aw_fire) state_d = W_RESP;
            W_RESP:   if (bready)  state_d = W_IDLE;
            default:  state_d = W_IDLE;
        endcase
    end

    always_comb begin
        awready = (state_q == W_IDLE) || (state_q == W_HAVE_D);
        wready  = (state_q == W_IDLE) || (state_q == W_HAVE_A);
        bvalid  = (state_q == W_RESP);
        bresp   = RESP_OKAY;
        aw_fire = awvalid && awready;
        w_fire  = wvalid && wready;
        commit  = ((state_q == W_IDLE) && aw_fire && w_fire) ||
                  ((state_q == W_HAVE_A) && w_fire) ||
                  ((state_q == W_HAVE_D) && aw_fire);
        c_addr  = aw_fire ? awaddr : addr_q;
        c_data  = w_fire ? wdata : data_q;
        c_strb  = w_fire ? wstrb : strb_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            strb_q <= '0;
        end else begin
            if (aw_fire) addr_q <= awaddr;
            if (w_fire) begin
                data_q <= wdata;
                strb_q <= wstrb;
            end
        end
    end

    AST_BVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid && !bready |=> bvalid) else $error("bvalid dropped"); // R10
    AST_COMMIT_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> bvalid) else $error("write without response"); // R9
endmodule

// File: rtl/acc_ctl_rd.sv
module acc_ctl_rd
    import acc_ctl_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter int              DATA_W   = 32,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 'h00,
    parameter logic [ADDR_W-1:0] BASE_OFS = 'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] araddr,
    input  logic              arvalid,
    output logic              arready,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        rresp,
    output logic              rvalid,
    input  logic              rready,
    input  logic [DATA_W-1:0] ctrl_word,
    input  logic [DATA_W-1:0] base_word,
    output logic              done_clr
);
    rd_state_e         state_q, state_d;
    logic [DATA_W-1:0] rdata_q;
    logic              is_ctrl_q;
    logic              ar_fire;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= R_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            R_IDLE:  if (ar_fire) state_d = R_RESP;
            R_RESP:  if (rready)  state_d = R_IDLE;
            default: state_d = R_IDLE;
        endcase
    end

    always_comb begin
        arready  = (state_q == R_IDLE);
        rvalid   = (state_q == R_RESP);
        rresp    = RESP_OKAY;
        rdata    = rdata_q;
        ar_fire  = arvalid && arready;
        done_clr = rvalid && rready && is_ctrl_q && rdata_q[CTRL_DONE];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q   <= '0;
            is_ctrl_q <= 1'b0;
        end else if (ar_fire) begin
            is_ctrl_q <= (araddr == CTRL_OFS);
            if (araddr == CTRL_OFS)      rdata_q <= ctrl_word;
            else if (araddr == BASE_OFS) rdata_q <= base_word;
            else                         rdata_q <= '0;
        end
    end

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid && !rready |=> rvalid && $stable(rdata)) else $error("read data not held"); // R10
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid && is_ctrl_q |-> (rdata[6:4] == 3'b000) && (rdata[DATA_W-1:8] == '0))
        else $error("reserved control bits set"); // R1
endmodule

// File: rtl/acc_ctl_bank.sv
module acc_ctl_bank
    import acc_ctl_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter int              DATA_W   = 32,
    parameter int              STRB_W   = DATA_W / 8,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 'h00,
    parameter logic [ADDR_W-1:0] BASE_OFS = 'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [ADDR_W-1:0] c_addr,
    input  logic [DATA_W-1:0] c_data,
    input  logic [STRB_W-1:0] c_strb,
    input  logic              done_clr,
    input  logic              core_ready,
    input  logic              core_idle,
    input  logic              core_done,
    output logic              core_start,
    output logic [DATA_W-1:0] ctrl_word,
    output logic [DATA_W-1:0] base_word
);
    logic              start_q, done_q, auto_q;
    logic [DATA_W-1:0] base_q, byte_mask;
    logic              ctrl_wr, base_wr, sw_set, accept, relaunch;

    for (genvar b = 0; b < STRB_W; b++) begin : g_mask
        assign byte_mask[8*b +: 8] = {8{c_strb[b]}};
    end

    always_comb begin
        ctrl_wr  = commit && (c_addr == CTRL_OFS) && c_strb[0];
        base_wr  = commit && (c_addr == BASE_OFS);
        sw_set   = ctrl_wr && c_data[CTRL_START];
        accept   = start_q && core_ready;
        relaunch = auto_q && core_done;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            done_q  <= 1'b0;
            auto_q  <= 1'b0;
            base_q  <= '0;
        end else begin
            start_q <= (start_q && !accept) || sw_set || relaunch;
            done_q  <= core_done || (done_q && !done_clr);
            if (ctrl_wr) auto_q <= c_data[CTRL_AUTO];
            if (base_wr) base_q <= (base_q & ~byte_mask) | (c_data & byte_mask);
        end
    end

    always_comb begin
        ctrl_word             = '0;
        ctrl_word[CTRL_START] = start_q;
        ctrl_word[CTRL_DONE]  = done_q;
        ctrl_word[CTRL_IDLE]  = core_idle;
        ctrl_word[CTRL_READY] = core_ready;
        ctrl_word[CTRL_AUTO]  = auto_q;
        base_word             = base_q;
        core_start            = start_q;
    end

    AST_START_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        core_start && !core_ready |=> core_start) else $error("start lost"); // R2
    AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        core_done |=> ctrl_word[CTRL_DONE]) else $error("done not latched"); // R3
    AST_AUTO_RELAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_word[CTRL_AUTO] && core_done |=> core_start) else $error("no relaunch"); // R5
endmodule

// File: rtl/acc_ctl_regs.sv
module acc_ctl_regs
    import acc_ctl_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter int              DATA_W   = 32,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 'h00,
    parameter logic [ADDR_W-1:0] BASE_OFS = 'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [DATA_W-1:0] s_wdata,
    input  logic [DATA_W/8-1:0] s_wstrb,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [DATA_W-1:0] s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic              core_start,
    input  logic              core_ready,
    input  logic              core_idle,
    input  logic              core_done,
    output logic [DATA_W-1:0] base_addr
);
    localparam int STRB_W = DATA_W / 8;

    logic              commit, done_clr;
    logic [ADDR_W-1:0] c_addr;
    logic [DATA_W-1:0] c_data, ctrl_word, base_word;
    logic [STRB_W-1:0] c_strb;

    acc_ctl_wr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STRB_W(STRB_W)) u_wr (
        .clk(clk), .rst_n(rst_n),
        .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
        .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
        .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
        .commit(commit), .c_addr(c_addr), .c_data(c_data), .c_strb(c_strb)
    );

    acc_ctl_rd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_OFS(CTRL_OFS), .BASE_OFS(BASE_OFS)) u_rd (
        .clk(clk), .rst_n(rst_n),
        .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
        .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
        .ctrl_word(ctrl_word), .base_word(base_word), .done_clr(done_clr)
    );

    acc_ctl_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STRB_W(STRB_W),
                   .CTRL_OFS(CTRL_OFS), .BASE_OFS(BASE_OFS)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .commit(commit), .c_addr(c_addr), .c_data(c_data), .c_strb(c_strb),
        .done_clr(done_clr), .core_ready(core_ready), .core_idle(core_idle),
        .core_done(core_done), .core_start(core_start),
        .ctrl_word(ctrl_word), .base_word(base_word)
    );

    assign base_addr = base_word;
endmodule

// File: tb/acc_ctl_regs_bench.sv
module acc_ctl_stub #(parameter int LAT = 20) (
    input  logic clk,
    input  logic rst_n,
    input  logic stall,
    input  logic start,
    output logic ready,
    output logic idle,
    output logic done
);
    logic       run_q;
    logic [7:0] cnt_q;
    assign ready = !run_q && !stall;
    assign idle  = !run_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0; cnt_q <= '0; done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!run_q && start && ready) begin
                run_q <= 1'b1; cnt_q <= '0;
            end else if (run_q) begin
                if (cnt_q == 8'(LAT - 1)) begin run_q <= 1'b0; done <= 1'b1; end
                else cnt_q <= cnt_q + 8'd1;
            end
        end
    end
endmodule

module acc_ctl_regs_bench;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic [7:0]  awaddr = '0, araddr = '0;
    logic        awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = '0;
    logic        awready, wready, bvalid, arready, rvalid;
    logic [1:0]  bresp, rresp;
    logic [31:0] rdata, base_addr;
    logic        core_start, core_ready, core_idle, core_done, stall = 1'b0;
    int          errors = 0, checks = 0, launches = 0;
    logic [31:0] model_base = '0;

    always #5 clk = ~clk;

    acc_ctl_regs u_acc_ctl_regs (
        .clk(clk), .rst_n(rst_n),
        .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
        .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
        .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
        .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
        .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
        .core_start(core_start), .core_ready(core_ready), .core_idle(core_idle),
        .core_done(core_done), .base_addr(base_addr)
    );

    acc_ctl_stub #(.LAT(20)) u_stub (
        .clk(clk), .rst_n(rst_n), .stall(stall), .start(core_start),
        .ready(core_ready), .idle(core_idle), .done(core_done)
    );

    always @(posedge clk) if (rst_n && core_start && core_ready) launches <= launches + 1;

    function automatic logic [31:0] ctl(input bit st, input bit dn, input bit id,
                                        input bit rd, input bit au);
        return {24'd0, au, 3'b000, rd, id, dn, st};
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                          input logic [3:0] s);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++) if (s[b]) r[8*b +: 8] = d[8*b +: 8];
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic axi_wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s,
                          input int order);
        bit aw_done = 0, w_done = 0, aw_hit, w_hit;
        @(negedge clk);
        awaddr = a; wdata = d; wstrb = s;
        awvalid = (order != 2); wvalid = (order != 1);
        while (!(aw_done && w_done)) begin
            aw_hit = awvalid && awready;
            w_hit  = wvalid && wready;
            @(negedge clk);
            if (aw_hit) begin aw_done = 1; awvalid = 0; end
            if (w_hit)  begin w_done = 1;  wvalid = 0;  end
            if (aw_done && !w_done) wvalid = 1;
            if (w_done && !aw_done) awvalid = 1;
        end
        bready = 1;
        while (!bvalid) @(negedge clk);
        check("R9 bresp", {30'd0, bresp}, 32'd0);
        @(negedge clk);
        bready = 0;
        check("R9 single response", {31'd0, bvalid}, 32'd0);
    endtask

    task automatic axi_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        araddr = a; arvalid = 1;
        while (!arready) @(negedge clk);
        @(negedge clk);
        arvalid = 0;
        if ($urandom_range(0, 2) == 0) begin
            @(negedge clk);
            @(negedge clk);
        end
        rready = 1;
        while (!rvalid) @(negedge clk);
        d = rdata;
        check("R9 rresp", {30'd0, rresp}, 32'd0);
        @(negedge clk);
        rready = 0;
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                errors++; checks++;
                $display("FAIL watchdog: actual=%0d expected<%0d", cyc, 100000);
                finish_run();
            end
        end
    end

    initial begin
        logic [31:0] v;
        int l0;
        void'($urandom(32'h5eed_0042));
        repeat (5) @(negedge clk);
        rst_n = 1;

        // R7 / R1 / R4: reset state
        axi_rd(8'h00, v); check("R7 R1 R4 ctrl after reset", v, ctl(0, 0, 1, 1, 0));
        axi_rd(8'h10, v); check("R7 base after reset", v, 32'd0);
        check("R7 base_addr port", base_addr, 32'd0);

        // R6: full write then partial strobes in each channel order
        axi_wr(8'h10, 32'h1234_5678, 4'hF, 0); model_base = 32'h1234_5678;
        check("R6 base_addr port", base_addr, model_base);
        axi_wr(8'h10, 32'hAABB_CCDD, 4'b0101, 1); model_base = merge(model_base, 32'hAABB_CCDD, 4'b0101);
        axi_rd(8'h10, v); check("R6 strobe merge aw first", v, model_base);
        axi_wr(8'h10, 32'h0F0F_0F0F, 4'b1000, 2); model_base = merge(model_base, 32'h0F0F_0F0F, 4'b1000);
        axi_rd(8'h10, v); check("R6 strobe merge w first", v, model_base);

        // R8: unmapped
        axi_wr(8'h0C, 32'hFFFF_FFFF, 4'hF, 0);
        check("R8 unmapped write ignored", base_addr, model_base);
        axi_rd(8'h0C, v); check("R8 unmapped read zero", v, 32'd0);

        // R2 / R3 / R4: simple run
        l0 = launches;
        axi_wr(8'h00, 32'h1, 4'h1, 0);
        axi_rd(8'h00, v); check("R2 R4 running", v, ctl(0, 0, 0, 0, 0));
        check("R2 one launch", launches - l0, 1);
        repeat (40) @(negedge clk);
        axi_rd(8'h00, v); check("R3 done set", v, ctl(0, 1, 1, 1, 0));
        axi_rd(8'h00, v); check("R3 done cleared by read", v, ctl(0, 0, 1, 1, 0));

        // R2: start held while core not ready, write 0 cannot clear
        stall = 1;
        axi_wr(8'h00, 32'h1, 4'h1, 1);
        axi_rd(8'h00, v); check("R2 start pending", v, ctl(1, 0, 1, 0, 0));
        axi_wr(8'h00, 32'h0, 4'h1, 2);
        axi_rd(8'h00, v); check("R2 write 0 no clear", v, ctl(1, 0, 1, 0, 0));
        check("R2 core_start held", {31'd0, core_start}, 32'd1);
        l0 = launches;
        @(negedge clk); stall = 0;
        repeat (40) @(negedge clk);
        check("R2 accepted once", launches - l0, 1);
        axi_rd(8'h00, v); check("R3 done after stalled run", v, ctl(0, 1, 1, 1, 0));
        axi_rd(8'h00, v); check("R3 cleared", v, ctl(0, 0, 1, 1, 0));

        // R3: done not cleared by read of other offsets
        axi_wr(8'h00, 32'h1, 4'h1, 0);
        repeat (40) @(negedge clk);
        axi_rd(8'h10, v); check("R6 base read", v, model_base);
        axi_rd(8'h00, v); check("R3 done survives other read", v, ctl(0, 1, 1, 1, 0));

        // R5: auto relaunch
        l0 = launches;
        axi_wr(8'h00, 32'h81, 4'h1, 0);
        repeat (100) @(negedge clk);
        check("R5 relaunches", (launches - l0 >= 3) ? 32'd1 : 32'd0, 32'd1);
        axi_wr(8'h00, 32'h0, 4'h1, 0);
        repeat (60) @(negedge clk);
        l0 = launches;
        repeat (60) @(negedge clk);
        check("R5 auto off stops", launches - l0, 0);
        axi_rd(8'h00, v); check("R5 R3 final ctrl", v, ctl(0, 1, 1, 1, 0));
        axi_rd(8'h00, v); check("R3 final clear", v, ctl(0, 0, 1, 1, 0));

        // Random traffic on base and unmapped offsets
        for (int i = 0; i < 80; i++) begin
            logic [7:0]  a;
            logic [31:0] d = $urandom;
            logic [3:0]  s = 4'($urandom);
            int          op = $urandom_range(0, 3);
            a = {$urandom_range(0, 63), 2'b00};
            if (a == 8'h00 || a == 8'h10) a = a + 8'h04;
            case (op)
                0: begin
                    axi_wr(8'h10, d, s, $urandom_range(0, 2));
                    model_base = merge(model_base, d, s);
                    check("R6 random base write", base_addr, model_base);
                end
                1: begin
                    axi_wr(a, d, s, $urandom_range(0, 2));
                    check("R8 random unmapped write", base_addr, model_base);
                end
                2: begin axi_rd(8'h10, v); check("R6 random base read", v, model_base); end
                default: begin axi_rd(a, v); check("R8 random unmapped read", v, 32'd0); end
            endcase
        end
        axi_rd(8'h00, v); check("R1 ctrl after random", v, ctl(0, 0, 1, 1, 0));
        finish_run();
    end
endmodule